// File: doc/BRIEF.md
# Deflection and Blanking Timing Generator

This block derives the raster timing pulses for a display path from a single display-rate clock. A horizontal pixel counter sets the line period. From it come a line reference with a 50% duty factor, a fixed-width horizontal deflection pulse at the start of each line, and a horizontal blanking pulse. The blanking pulse has a programmable start and end, counted from the rising edge of the line reference. With the default 1024-cycle line and a 32 MHz display clock, one line lasts 32 µs.

The line counter normally runs free and wraps at its terminal count. When both sides of the video path share one clock, the single-clock enable can be set. The counter is then also forced to zero by each rising edge of an external line-sync input, so the display raster follows the acquired line.

Vertical timing uses half-line units, which are 16 µs at the default rate. An external vertical sync is resynchronised and edge-detected. Its rising edge clears a half-line counter, and a vertical deflection pulse opens and closes at programmable half-line counts. The frame cadence, for example a 10 ms field, is set by the spacing of the vertical sync edges.

Top module: `defl_timing_gen`

## Requirements
- R1: While `rst_n` is low the line counter is held at 0, so `line_ref_out` and `hdef_out` are high and `blank_out` and `vdef_out` are low.
- R2: In free-running mode the line counter counts 0 to LINE_CYCLES-1 and wraps to 0. `line_ref_out` is high while the count is below LINE_CYCLES/2, which gives a 50% duty factor with its rising edge at count 0.
- R3: `hdef_out` is high while the line count is below HDEF_CYCLES, so each line carries one pulse of exactly HDEF_CYCLES cycles that starts at count 0.
- R4: `blank_out` rises on the clock after the line count equals `blank_start` and falls on the clock after it equals `blank_stop`. When `blank_start` > `blank_stop` the window wraps across count 0.
- R5: When a pulse's start value equals its stop value, that output (`blank_out` or `vdef_out`) stays low.
- R6: `vsync_in` passes through two synchroniser flops and a rising-edge detector. The half-line counter becomes 0 three clocks after the first clock edge that samples `vsync_in` high. `vdef_out` rises on the clock after that counter equals `vdef_start` and falls on the clock after it equals `vdef_stop`.
- R7: The half-line counter saturates at its all-ones value until the next vertical sync edge.
- R8: With `single_clk_en` high, a rising edge on `line_sync_in` (input high, previous sample low) forces the line count to 0 on the next clock. With `single_clk_en` low, `line_sync_in` has no effect.
- R9: The half-line counter advances once on each clock whose line count is 0 or LINE_CYCLES/2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Display clock |
| rst_n | input | 1 | Active-low synchronous reset |
| single_clk_en | input | 1 | Lets line-sync edges restart the line counter |
| line_sync_in | input | 1 | External line sync, synchronous to clk |
| vsync_in | input | 1 | External vertical sync, asynchronous |
| blank_start | input | CNT_W | Line count at which blanking opens |
| blank_stop | input | CNT_W | Line count at which blanking closes |
| vdef_start | input | VCNT_W | Half-line count at which vertical deflection opens |
| vdef_stop | input | VCNT_W | Half-line count at which vertical deflection closes |
| hdef_out | output | 1 | Horizontal deflection pulse |
| vdef_out | output | 1 | Vertical deflection pulse |
| blank_out | output | 1 | Horizontal blanking pulse |
| line_ref_out | output | 1 | 50% duty line reference |

## Verification
A reduced configuration (32-cycle line, 5-cycle deflection pulse, 6-bit half-line counter) is swept cycle by cycle for tens of lines per pattern. The patterns are:
- A blanking window that lies inside the line, which separates correct start/stop ordering from an off-by-one in the set/clear timing.
- A window that wraps across count 0.
- Equal start and stop values, which catches a missing empty-window guard.

Vertical sync is applied at a short frame period and at one long enough to reach saturation. A window placed at the top count shows up a counter that wraps instead of holding. Toggling line sync with single-clock mode off, and then with it on at a period shorter than the line, separates the ignored case from a correct restart.

// File: rtl/defl_pkg.sv
package defl_pkg;

  // Set/clear window state: empty window forces low, start wins over stop.
  function automatic logic window_next(logic cur, logic hit_start,
                                       logic hit_stop, logic empty);
    if (empty)          return 1'b0;
    else if (hit_start) return 1'b1;
    else if (hit_stop)  return 1'b0;
    else                return cur;
  endfunction

  // Modulo counter with an external restart.
  function automatic int unsigned wrap_next(int unsigned cnt, int unsigned last,
                                            logic restart);
    if (restart || cnt == last) return 0;
    return cnt + 1;
  endfunction

  // Saturating counter with clear and step enable.
  function automatic int unsigned sat_next(int unsigned cnt, int unsigned top,
                                           logic clear, logic step);
    if (clear)                  return 0;
    if (step && cnt != top)     return cnt + 1;
    return cnt;
  endfunction

endpackage

// File: rtl/defl_line_ctr.sv
module defl_line_ctr #(
  parameter int LINE_CYCLES = 1024,
  parameter int HDEF_CYCLES = 76,
  localparam int CW = $clog2(LINE_CYCLES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          single_en,
  input  logic          line_sync_in,
  output logic [CW-1:0] hcnt,
  output logic          line_edge,
  output logic          half_tick,
  output logic          line_ref,
  output logic          hdef
);
  localparam int unsigned LAST = LINE_CYCLES - 1;
  localparam logic [CW-1:0] HALF = CW'(LINE_CYCLES / 2);
  localparam logic [CW-1:0] HDEF_END = CW'(HDEF_CYCLES);

  logic sync_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      hcnt   <= '0;
    end else begin
      sync_q <= line_sync_in;
      hcnt   <= CW'(defl_pkg::wrap_next(32'(hcnt), LAST, line_edge));
    end
  end

  assign line_edge = single_en & line_sync_in & ~sync_q;
  assign half_tick = (hcnt == '0) | (hcnt == HALF);
  assign line_ref  = hcnt < HALF;
  assign hdef      = hcnt < HDEF_END;
endmodule

// File: rtl/defl_sync_edge.sv
module defl_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [2:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[1:0], async_in};
  end

  assign rise = sh[1] & ~sh[2];
endmodule

// File: rtl/defl_vert_ctr.sv
module defl_vert_ctr #(
  parameter int VCNT_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              tick,
  output logic [VCNT_W-1:0] vcnt
);
  localparam int unsigned TOP = (1 << VCNT_W) - 1;

  always_ff @(posedge clk) begin
    if (!rst_n) vcnt <= '0;
    else        vcnt <= VCNT_W'(defl_pkg::sat_next(32'(vcnt), TOP, clear, tick));
  end
endmodule

// File: rtl/defl_window.sv
module defl_window #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pos,
  input  logic [W-1:0] start,
  input  logic [W-1:0] stop,
  output logic         pulse
);
  always_ff @(posedge clk) begin
    if (!rst_n) pulse <= 1'b0;
    else        pulse <= defl_pkg::window_next(pulse, pos == start,
                                               pos == stop, start == stop);
  end
endmodule

// File: rtl/defl_timing_gen.sv
module defl_timing_gen #(
  parameter int LINE_CYCLES = 1024,
  parameter int HDEF_CYCLES = 76,
  parameter int VCNT_W      = 10,
  localparam int CNT_W = $clog2(LINE_CYCLES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              single_clk_en,
  input  logic              line_sync_in,
  input  logic              vsync_in,
  input  logic [CNT_W-1:0]  blank_start,
  input  logic [CNT_W-1:0]  blank_stop,
  input  logic [VCNT_W-1:0] vdef_start,
  input  logic [VCNT_W-1:0] vdef_stop,
  output logic              hdef_out,
  output logic              vdef_out,
  output logic              blank_out,
  output logic              line_ref_out
);
  // Internal events, named for the checker.
  logic [CNT_W-1:0]  hcnt;
  logic              line_edge;
  logic              half_tick;
  logic              v_edge;
  logic [VCNT_W-1:0] vcnt;

  defl_line_ctr #(.LINE_CYCLES(LINE_CYCLES), .HDEF_CYCLES(HDEF_CYCLES)) u_line (
    .clk(clk), .rst_n(rst_n), .single_en(single_clk_en),
    .line_sync_in(line_sync_in), .hcnt(hcnt), .line_edge(line_edge),
    .half_tick(half_tick), .line_ref(line_ref_out), .hdef(hdef_out)
  );

  defl_sync_edge u_vsync (
    .clk(clk), .rst_n(rst_n), .async_in(vsync_in), .rise(v_edge)
  );

  defl_vert_ctr #(.VCNT_W(VCNT_W)) u_vert (
    .clk(clk), .rst_n(rst_n), .clear(v_edge), .tick(half_tick), .vcnt(vcnt)
  );

  defl_window #(.W(CNT_W)) u_blank (
    .clk(clk), .rst_n(rst_n), .pos(hcnt), .start(blank_start),
    .stop(blank_stop), .pulse(blank_out)
  );

  defl_window #(.W(VCNT_W)) u_vdef (
    .clk(clk), .rst_n(rst_n), .pos(vcnt), .start(vdef_start),
    .stop(vdef_stop), .pulse(vdef_out)
  );
endmodule

// File: rtl/defl_timing_gen_chk.sv
module defl_timing_gen_chk #(
  parameter int LINE_CYCLES = 1024,
  parameter int HDEF_CYCLES = 76,
  parameter int VCNT_W      = 10,
  localparam int CNT_W = $clog2(LINE_CYCLES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              single_clk_en,
  input logic              line_edge,
  input logic [CNT_W-1:0]  hcnt,
  input logic              half_tick,
  input logic              v_edge,
  input logic [VCNT_W-1:0] vcnt,
  input logic              line_ref_out,
  input logic              hdef_out,
  input logic              blank_out,
  input logic [CNT_W-1:0]  blank_start,
  input logic [CNT_W-1:0]  blank_stop
);
  localparam logic [CNT_W-1:0]  LAST = CNT_W'(LINE_CYCLES - 1);
  localparam logic [CNT_W-1:0]  HEND = CNT_W'(HDEF_CYCLES);
  localparam logic [VCNT_W-1:0] VTOP = '1;

  assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt == LAST && !line_edge) |=> hcnt == '0);

  assert_ref_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_ref_out) |-> hcnt == '0);

  assert_hdef_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hdef_out) |-> hcnt == HEND);

  assert_blank_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blank_out) |-> $past(hcnt) == $past(blank_start));

  assert_blank_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_start == blank_stop) |=> !blank_out);

  assert_vclear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    v_edge |=> vcnt == '0);

  assert_vsat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vcnt == VTOP && !v_edge) |=> vcnt == VTOP);

  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (single_clk_en && line_edge) |=> hcnt == '0);

  assert_vhold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!half_tick && !v_edge) |=> $stable(vcnt));
endmodule

bind defl_timing_gen defl_timing_gen_chk #(
  .LINE_CYCLES(LINE_CYCLES), .HDEF_CYCLES(HDEF_CYCLES), .VCNT_W(VCNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .single_clk_en(single_clk_en),
  .line_edge(line_edge), .hcnt(hcnt), .half_tick(half_tick),
  .v_edge(v_edge), .vcnt(vcnt), .line_ref_out(line_ref_out),
  .hdef_out(hdef_out), .blank_out(blank_out),
  .blank_start(blank_start), .blank_stop(blank_stop)
);

// File: tb/defl_timing_gen_tb.sv
module defl_timing_gen_tb;
  localparam int L    = 32;
  localparam int HALF = L / 2;
  localparam int HD   = 5;
  localparam int VW   = 6;
  localparam int VMAX = (1 << VW) - 1;
  localparam int CW   = $clog2(L);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic single_clk_en = 1'b0;
  logic line_sync_in = 1'b0;
  logic vsync_in = 1'b0;
  logic [CW-1:0] blank_start = '0, blank_stop = '0;
  logic [VW-1:0] vdef_start = '0, vdef_stop = '0;
  logic hdef_out, vdef_out, blank_out, line_ref_out;

  always #5 clk = ~clk;

  defl_timing_gen #(.LINE_CYCLES(L), .HDEF_CYCLES(HD), .VCNT_W(VW)) u_dut (
    .clk(clk), .rst_n(rst_n), .single_clk_en(single_clk_en),
    .line_sync_in(line_sync_in), .vsync_in(vsync_in),
    .blank_start(blank_start), .blank_stop(blank_stop),
    .vdef_start(vdef_start), .vdef_stop(vdef_stop),
    .hdef_out(hdef_out), .vdef_out(vdef_out),
    .blank_out(blank_out), .line_ref_out(line_ref_out)
  );

  int vectors = 0, fails = 0;
  bit done = 0;
  int h = 0, vb = 0, cyc = 0, pc = 0, clr_at = -1;
  logic eb = 0, ev = 0, ls_prev = 0, vs_prev = 0;
  int vs_period = 0, ls_period = 0, bguard = 0, vguard = 0;
  string ltag = "R2", btag = "R4", vtag = "R6 R9";

  function automatic logic inw(int p, int s, int e);
    if (s == e) return 1'b0;
    if (s < e)  return (p >= s) && (p < e);
    return (p >= s) || (p < e);
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      logic rst_edge;
      logic tick;
      chk(ltag, line_ref_out, h < HALF);
      chk("R3", hdef_out, h < HD);
      if (bguard == 0) chk(btag, blank_out, eb); else bguard--;
      if (vguard == 0) chk(vtag, vdef_out, ev); else vguard--;
      pc++;
      vsync_in     = (vs_period > 0) && ((pc % vs_period) < 3);
      line_sync_in = (ls_period > 0) && ((pc % ls_period) < 2);
      rst_edge = single_clk_en && line_sync_in && !ls_prev;
      ls_prev  = line_sync_in;
      if (vsync_in && !vs_prev) clr_at = cyc + 3;
      vs_prev = vsync_in;
      eb   = inw(h, int'(blank_start), int'(blank_stop));
      ev   = inw(vb, int'(vdef_start), int'(vdef_stop));
      tick = (h == 0) || (h == HALF);
      if (cyc + 1 == clr_at)       vb = 0;
      else if (tick && vb < VMAX)  vb = vb + 1;
      h = rst_edge ? 0 : ((h == L - 1) ? 0 : h + 1);
      cyc++;
      @(negedge clk);
    end
  endtask

  initial begin
    blank_start = CW'(6);  blank_stop = CW'(20);
    vdef_start  = VW'(3);  vdef_stop  = VW'(9);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R1", line_ref_out, 1'b1);
      chk("R1", hdef_out, 1'b1);
      chk("R1", blank_out, 1'b0);
      chk("R1", vdef_out, 1'b0);
    end
    rst_n = 1'b1;
    // Free-running, inner windows; line sync toggles but is ignored (R8).
    vs_period = 640; ls_period = 7; ltag = "R2 R8";
    run(2000);
    // Wrapping blank window (R4) and empty vertical window (R5).
    ls_period = 0; ltag = "R2";
    blank_start = CW'(28); blank_stop = CW'(4);
    vdef_start = VW'(5); vdef_stop = VW'(5);
    btag = "R4"; vtag = "R5"; bguard = L + 2; vguard = 2 * vs_period;
    run(2600);
    // Empty blank window (R5); window at the top of the half-line count (R7).
    blank_start = CW'(10); blank_stop = CW'(10);
    vdef_start = VW'(62); vdef_stop = VW'(63);
    vs_period = 2560;
    btag = "R5"; vtag = "R7"; bguard = L + 2; vguard = 2 * vs_period;
    run(3 * 2560 + 2 * 2560);
    // Single-clock mode: line sync restarts the counter every 24 cycles (R8).
    single_clk_en = 1'b1; ls_period = 24; vs_period = 640;
    blank_start = CW'(6); blank_stop = CW'(20);
    vdef_start = VW'(3); vdef_stop = VW'(9);
    ltag = "R8"; btag = "R4 R8"; vtag = "R6 R9";
    bguard = L + 2; vguard = 2 * vs_period;
    run(3000);
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule